// File: doc/BRIEF.md
# Variable Latency Burst Bus Controller

This block is the host side of an asynchronous, SRAM-like bus toward a companion device that can slow any access down. A requester supplies a read or write command with a start byte address, a beat count, a flag that freezes the address, and two timing values: the shortest allowed strobe-low time and the strobe-high time between beats. The controller then lowers chip select. For every beat it pulses the output-enable strobe (reads) or the write strobe (writes) once. It raises chip select again once the burst is complete.

The device holds a ready line low to stretch a beat. That line is brought into the clock domain through a two-flop synchronizer. A beat completes only after the synchronized value has been seen high on three sampled edges, and sampling begins in the third strobe-low cycle. There is no timeout, so a device that never answers holds the burst open. On writes, the data and the active-low lane enables for each beat are taken from the requester through a beat index output. A beat whose lanes are all disabled keeps its full time slot but never lowers the write strobe.

Top module: `varlat_bus_ctrl`

## Requirements
- R1: While reset is held, and after it until a burst starts, busCsN, busOeN and busWeN are 1, busBeN is all ones, and done, rdValid and busy are 0.
- R2: A start seen in idle lowers busCsN in the next cycle. The strobe stays high for the first two chip-select cycles and the first beat's strobe goes low in the third.
- R3: Each beat is one separate strobe-low pulse. Between two beats both strobes are high for exactly cfgStrobeGap+1 cycles while busCsN stays low.
- R4: busRdy passes two flops. Samples are taken on the edges that end strobe cycles 2, 3, 4 and so on (numbered from 0). If the raw input is high from strobe cycle W onward, the strobe stays low for max(W+7, cfgStrobeMin+1) cycles.
- R5: A read beat captures busRdData on the edge one cycle after the third high sample. rdValid is 1 for exactly one cycle, strobe cycle max(2,W+2)+4, while busOeN is still low, and rdData holds the captured word during that cycle.
- R6: Without the freeze flag, beat b uses byte address reqAddr+4*b modulo 2^26. busAddr is stable while the strobe is low and changes at the end of the first strobe-high cycle after a beat.
- R7: With reqNoInc set, every beat of the burst uses reqAddr unchanged.
- R8: On writes, busWrData and busBeN follow wrData and wrMask for the current beatIndex, which counts beats from 0. On reads, busBeN is 0 (all four lanes enabled). busBeN bit 3 is the most significant byte lane.
- R9: A write beat with wrMask equal to 4'b1111 keeps busWeN at 1 for its whole slot. busCsN stays low and the slot lasts exactly as long as an unmasked beat, including for a one-beat burst.
- R10: After the last strobe rises, busCsN and busBeN stay asserted for one more cycle. busCsN then goes high and done is 1 for exactly that first idle cycle.
- R11: A start that arrives while busy is 1 does not alter the running burst and does not start a new one.
- R12: The controller waits for ready with no limit: a ready held low for 300 strobe cycles stretches the beat by the same amount.
- R13: A burst has reqLenM1+1 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| reqRead | input | 1 | 1 for a read burst, 0 for a write burst |
| reqAddr | input | 26 | Start byte address |
| reqLenM1 | input | 4 | Beat count minus one |
| reqNoInc | input | 1 | Keep the address fixed for all beats |
| cfgStrobeMin | input | 4 | Minimum strobe-low time minus one, in cycles |
| cfgStrobeGap | input | 4 | Strobe-high time between beats minus one, in cycles |
| wrData | input | 32 | Write data for the beat shown on beatIndex |
| wrMask | input | 4 | Active-low lane enables for the beat shown on beatIndex |
| beatIndex | output | 4 | Number of the current beat within the burst |
| busRdy | input | 1 | Asynchronous ready from the device, low to stretch |
| busRdData | input | 32 | Read data from the device |
| busCsN | output | 1 | Chip select, active low |
| busOeN | output | 1 | Output enable strobe, active low |
| busWeN | output | 1 | Write strobe, active low |
| busBeN | output | 4 | Byte lane enables, active low |
| busAddr | output | 26 | Byte address |
| busWrData | output | 32 | Write data toward the device |
| rdData | output | 32 | Captured read word |
| rdValid | output | 1 | One-cycle strobe marking rdData |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse once chip select is released |

## Verification
The bench builds the block with its default parameters: a 26-bit address, 32-bit data, and 4-bit length and timing fields. With these, a start address near the top of the space shows the address wrap within a four-beat burst. The sweep covers every gap value from 0 to 3, strobe minimums both below and above the seven-cycle floor set by ready qualification (including the maximum of 15), and ready delays from 0 to 3 cycles, for both directions. Separate runs cover a 16-beat burst, a 300-cycle ready stall, masked write beats inside a burst and alone, and a start pulse injected in the middle of a burst.

// File: rtl/varlat_pkg.sv
package varlat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SAMPLE,
    ST_CAPTURE,
    ST_HOLD,
    ST_GAP,
    ST_TAIL
  } busState_t;

  // Strobes from sequencing control to the datapath.
  typedef struct packed {
    logic loadReq;       // latch the request this cycle
    logic csActive;      // chip select asserted
    logic strobeActive;  // beat strobe slot (read or write)
    logic captureRead;   // take bus read data at this edge
    logic nextBeat;      // advance beat index and address at this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/varlat_sync.sv
module varlat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/varlat_ctrl.sv
module varlat_ctrl
  import varlat_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int TIME_W      = 4,
  parameter int LEAD_CYCLES = 2,
  parameter int SAMPLE_FROM = 2,
  parameter int READY_HITS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  burstLenM1,
  input  logic [TIME_W-1:0] strobeMin,
  input  logic [TIME_W-1:0] strobeGap,
  input  logic              rdyAsync,
  output ctrlStrobes_t      ctl,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W = TIME_W + 1;
  localparam int HIT_W = $clog2(READY_HITS + 1);
  localparam int PH_W  = TIME_W;

  busState_t          state;
  logic [PH_W-1:0]    phaseCnt;
  logic [CNT_W-1:0]   strobeCnt;
  logic [HIT_W-1:0]   hitCnt;
  logic [LEN_W-1:0]   beatsLeft;
  logic [TIME_W-1:0]  minLat;
  logic [TIME_W-1:0]  gapLat;
  logic               rdySync;
  logic               sampleHit;
  logic               holdDone;
  logic [CNT_W-1:0]   strobeCntInc;

  varlat_sync #(.STAGES(SYNC_STAGES)) rdySyncInst (
    .clk (clk),
    .rstN(rstN),
    .din (rdyAsync),
    .dout(rdySync)
  );

  assign strobeCntInc = (strobeCnt == '1) ? strobeCnt : strobeCnt + CNT_W'(1);
  assign sampleHit = (state == ST_SAMPLE) && (strobeCnt >= CNT_W'(SAMPLE_FROM)) && rdySync;
  assign holdDone  = strobeCnt >= {1'b0, minLat};

  always_comb begin
    ctl.loadReq      = (state == ST_IDLE) && start;
    ctl.csActive     = (state != ST_IDLE);
    ctl.strobeActive = (state == ST_SAMPLE) || (state == ST_CAPTURE) || (state == ST_HOLD);
    ctl.captureRead  = (state == ST_CAPTURE);
    ctl.nextBeat     = (state == ST_GAP) && (phaseCnt == '0);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      strobeCnt <= '0;
      hitCnt    <= '0;
      beatsLeft <= '0;
      minLat    <= '0;
      gapLat    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_LEAD;
            phaseCnt  <= '0;
            beatsLeft <= burstLenM1;
            minLat    <= strobeMin;
            gapLat    <= strobeGap;
          end
        end
        ST_LEAD: begin
          if (phaseCnt == PH_W'(LEAD_CYCLES - 1)) begin
            state     <= ST_SAMPLE;
            strobeCnt <= '0;
            hitCnt    <= '0;
          end else begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        ST_SAMPLE: begin
          strobeCnt <= strobeCntInc;
          if (sampleHit) begin
            hitCnt <= hitCnt + HIT_W'(1);
            if (hitCnt == HIT_W'(READY_HITS - 1)) state <= ST_CAPTURE;
          end
        end
        ST_CAPTURE: begin
          strobeCnt <= strobeCntInc;
          state     <= ST_HOLD;
        end
        ST_HOLD: begin
          if (holdDone) begin
            phaseCnt <= '0;
            state    <= (beatsLeft == '0) ? ST_TAIL : ST_GAP;
          end else begin
            strobeCnt <= strobeCntInc;
          end
        end
        ST_GAP: begin
          if (phaseCnt == '0) beatsLeft <= beatsLeft - LEN_W'(1);
          if (phaseCnt >= gapLat) begin
            state     <= ST_SAMPLE;
            strobeCnt <= '0;
            hitCnt    <= '0;
          end else begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        ST_TAIL: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/varlat_datapath.sv
module varlat_datapath
  import varlat_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           ctl,
  input  logic                   reqRead,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic                   reqNoInc,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [DATA_W/8-1:0]    wrMask,
  input  logic [DATA_W-1:0]      busRdData,
  output logic [LEN_W-1:0]       beatIndex,
  output logic [ADDR_W-1:0]      busAddr,
  output logic [DATA_W-1:0]      busWrData,
  output logic [DATA_W/8-1:0]    busBeN,
  output logic                   busOeN,
  output logic                   busWeN,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid
);

  localparam int LANES = DATA_W / 8;

  logic              isRead;
  logic              noInc;
  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  beatIdx;
  logic [DATA_W-1:0] rdDataReg;
  logic              rdValidReg;
  logic              beatMasked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isRead     <= 1'b0;
      noInc      <= 1'b0;
      addrReg    <= '0;
      beatIdx    <= '0;
      rdDataReg  <= '0;
      rdValidReg <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        isRead  <= reqRead;
        noInc   <= reqNoInc;
        addrReg <= reqAddr;
        beatIdx <= '0;
      end else if (ctl.nextBeat) begin
        beatIdx <= beatIdx + LEN_W'(1);
        if (!noInc) addrReg <= addrReg + ADDR_W'(LANES);
      end
      rdValidReg <= ctl.captureRead && isRead;
      if (ctl.captureRead && isRead) rdDataReg <= busRdData;
    end
  end

  assign beatMasked = !isRead && (&wrMask);

  always_comb begin
    busOeN    = !(ctl.strobeActive && isRead);
    busWeN    = !(ctl.strobeActive && !isRead && !beatMasked);
    if (!ctl.csActive) busBeN = '1;
    else if (isRead)   busBeN = '0;
    else               busBeN = wrMask;
    busWrData = wrData;
    busAddr   = addrReg;
    beatIndex = beatIdx;
    rdData    = rdDataReg;
    rdValid   = rdValidReg;
  end

endmodule

// File: rtl/varlat_bus_ctrl.sv
module varlat_bus_ctrl
  import varlat_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 4,
  parameter int TIME_W      = 4,
  parameter int LEAD_CYCLES = 2,
  parameter int SAMPLE_FROM = 2,
  parameter int READY_HITS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   reqRead,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [LEN_W-1:0]       reqLenM1,
  input  logic                   reqNoInc,
  input  logic [TIME_W-1:0]      cfgStrobeMin,
  input  logic [TIME_W-1:0]      cfgStrobeGap,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [DATA_W/8-1:0]    wrMask,
  output logic [LEN_W-1:0]       beatIndex,
  input  logic                   busRdy,
  input  logic [DATA_W-1:0]      busRdData,
  output logic                   busCsN,
  output logic                   busOeN,
  output logic                   busWeN,
  output logic [DATA_W/8-1:0]    busBeN,
  output logic [ADDR_W-1:0]      busAddr,
  output logic [DATA_W-1:0]      busWrData,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid,
  output logic                   busy,
  output logic                   done
);

  ctrlStrobes_t ctl;

  varlat_ctrl #(
    .LEN_W      (LEN_W),
    .TIME_W     (TIME_W),
    .LEAD_CYCLES(LEAD_CYCLES),
    .SAMPLE_FROM(SAMPLE_FROM),
    .READY_HITS (READY_HITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .burstLenM1(reqLenM1),
    .strobeMin (cfgStrobeMin),
    .strobeGap (cfgStrobeGap),
    .rdyAsync  (busRdy),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  varlat_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqRead  (reqRead),
    .reqAddr  (reqAddr),
    .reqNoInc (reqNoInc),
    .wrData   (wrData),
    .wrMask   (wrMask),
    .busRdData(busRdData),
    .beatIndex(beatIndex),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busBeN   (busBeN),
    .busOeN   (busOeN),
    .busWeN   (busWeN),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  assign busCsN = !ctl.csActive;

endmodule

// File: rtl/varlat_bus_checker.sv
module varlat_bus_checker #(
  parameter int ADDR_W = 26,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busCsN,
  input logic              busOeN,
  input logic              busWeN,
  input logic [LANES-1:0]  busBeN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              rdValid,
  input logic              done
);

  // R1: with chip select released nothing else on the bus is asserted
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    busCsN |-> (busOeN && busWeN && (&busBeN)));

  // R2: the cycle after chip select falls is still strobe-free
  assert_lead_no_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busCsN) |=> (!busCsN && busOeN && busWeN));

  // R2: any strobe fall is preceded by at least two chip-select cycles
  assert_strobe_after_lead_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busOeN) || $fell(busWeN)) |-> !$past(busCsN, 2));

  // R3: never both strobes at once
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(!busOeN && !busWeN));

  // R6: address frozen across a read strobe
  assert_addr_steady_rd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busOeN && $past(!busOeN)) |-> $stable(busAddr));

  // R6: address frozen across a write strobe
  assert_addr_steady_wr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busWeN && $past(!busWeN)) |-> $stable(busAddr));

  // R5: read data is flagged only inside a read strobe
  assert_rdvalid_in_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !busOeN);

  // R10: chip select rises only after a strobe-free tail cycle
  assert_tail_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busCsN) |-> $past(busOeN && busWeN && !busCsN));

  // R10: done marks the first released cycle
  assert_done_after_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busCsN && $past(!busCsN)));

endmodule

bind varlat_bus_ctrl varlat_bus_checker #(
  .ADDR_W(ADDR_W),
  .LANES (DATA_W / 8)
) chkInst (
  .clk    (clk),
  .rstN   (rstN),
  .busCsN (busCsN),
  .busOeN (busOeN),
  .busWeN (busWeN),
  .busBeN (busBeN),
  .busAddr(busAddr),
  .rdValid(rdValid),
  .done   (done)
);

// File: tb/varlat_bus_ctrl_test.sv
`timescale 1ns/1ps
module varlat_bus_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        reqRead = 1'b0;
  logic [25:0] reqAddr = '0;
  logic [3:0]  reqLenM1 = '0;
  logic        reqNoInc = 1'b0;
  logic [3:0]  cfgStrobeMin = '0;
  logic [3:0]  cfgStrobeGap = '0;
  logic [31:0] wrData;
  logic [3:0]  wrMask;
  logic [3:0]  beatIndex;
  logic        busRdy = 1'b1;
  logic [31:0] busRdData;
  logic        busCsN, busOeN, busWeN;
  logic [3:0]  busBeN;
  logic [25:0] busAddr;
  logic [31:0] busWrData;
  logic [31:0] rdData;
  logic        rdValid, busy, done;

  logic [3:0]  maskVec [16];
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  varlat_bus_ctrl uut (
    .clk(clk), .rstN(rstN), .start(start), .reqRead(reqRead), .reqAddr(reqAddr),
    .reqLenM1(reqLenM1), .reqNoInc(reqNoInc), .cfgStrobeMin(cfgStrobeMin),
    .cfgStrobeGap(cfgStrobeGap), .wrData(wrData), .wrMask(wrMask),
    .beatIndex(beatIndex), .busRdy(busRdy), .busRdData(busRdData),
    .busCsN(busCsN), .busOeN(busOeN), .busWeN(busWeN), .busBeN(busBeN),
    .busAddr(busAddr), .busWrData(busWrData), .rdData(rdData),
    .rdValid(rdValid), .busy(busy), .done(done)
  );

  // device model: read word derived from the address; write data from beat number
  assign busRdData = {busAddr, 6'h2D};
  assign wrData    = 32'h5A00_0000 + 32'(beatIndex) * 32'h0001_0101;
  assign wrMask    = maskVec[beatIndex];

  function automatic logic [31:0] expWr(input int b);
    return 32'h5A00_0000 + 32'(b) * 32'h0001_0101;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic runBurst(input bit rd, input logic [25:0] a, input int lenM1, input bit ni,
                          input int rdf, input int rdn, input int w, input bit poke);
    int expL, rdvK;
    logic [25:0] expA, nxtA;
    bit masked;
    @(negedge clk);
    reqRead = rd; reqAddr = a; reqLenM1 = 4'(lenM1); reqNoInc = ni;
    cfgStrobeMin = 4'(rdf); cfgStrobeGap = 4'(rdn); busRdy = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 chip select low after start", 64'(busCsN), 64'(0));
    chk("R2 no strobe in lead cycle 0", 64'({busOeN, busWeN}), 64'(3));
    chk("R11 busy during burst", 64'(busy), 64'(1));
    @(negedge clk);
    chk("R2 no strobe in lead cycle 1", 64'({busCsN, busOeN, busWeN}), 64'(3));
    for (int b = 0; b <= lenM1; b++) begin
      expA = ni ? a : a + 26'(4 * b);
      nxtA = ni ? a : a + 26'(4 * (b + 1));
      expL = (w + 7 > rdf + 1) ? w + 7 : rdf + 1;
      rdvK = ((w + 2 > 2) ? w + 2 : 2) + 4;
      masked = !rd && (maskVec[b] == 4'hF);
      for (int k = 0; k < expL; k++) begin
        @(negedge clk);
        chk("R4 read strobe level in slot", 64'(busOeN), 64'(rd ? 0 : 1));
        chk(masked ? "R9 masked beat keeps write strobe high" : "R4 write strobe level in slot",
            64'(busWeN), 64'((rd || masked) ? 1 : 0));
        chk("R9 chip select held in slot", 64'(busCsN), 64'(0));
        chk(ni ? "R7 fixed address" : "R6 beat address", 64'(busAddr), 64'(expA));
        if (rd) begin
          chk("R8 read lanes all enabled", 64'(busBeN), 64'(0));
          chk("R5 rdValid timing", 64'(rdValid), 64'(k == rdvK));
          if (k == rdvK) chk("R5 read data", 64'(rdData), 64'({expA, 6'h2D}));
        end else begin
          chk("R8 write lanes", 64'(busBeN), 64'(maskVec[b]));
          chk("R8 write data", 64'(busWrData), 64'(expWr(b)));
          chk("R8 beat index", 64'(beatIndex), 64'(b));
        end
        if (poke && b == 0 && k == 1) begin start = 1'b1; reqAddr = ~a; reqRead = !rd; end
        if (poke && b == 0 && k == 2) begin start = 1'b0; reqAddr = a; reqRead = rd; end
        busRdy = (k >= w);
      end
      if (b < lenM1) begin
        for (int g = 0; g <= rdn; g++) begin
          @(negedge clk);
          chk("R3 strobes high between beats", 64'({busOeN, busWeN}), 64'(3));
          chk("R3 chip select held between beats", 64'(busCsN), 64'(0));
          chk("R6 address update point", 64'(busAddr), 64'(g == 0 ? expA : nxtA));
        end
      end else begin
        @(negedge clk);
        chk("R10 chip select held in tail", 64'(busCsN), 64'(0));
        chk("R10 strobes high in tail", 64'({busOeN, busWeN}), 64'(3));
        chk("R10 lanes held in tail", 64'(busBeN), 64'(rd ? 4'h0 : maskVec[b]));
        chk("R13 no early done", 64'(done), 64'(0));
      end
    end
    @(negedge clk);
    chk("R13 chip select released after last beat", 64'(busCsN), 64'(1));
    chk("R10 done pulse", 64'(done), 64'(1));
    chk("R10 lanes released", 64'(busBeN), 64'(4'hF));
    @(negedge clk);
    chk("R10 done one cycle", 64'(done), 64'(0));
    if (poke) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk("R11 no second burst", 64'(busCsN), 64'(1));
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int rdfList [4];
    rdfList[0] = 0; rdfList[1] = 6; rdfList[2] = 9; rdfList[3] = 15;
    for (int i = 0; i < 16; i++) maskVec[i] = 4'(i % 8);

    repeat (3) @(negedge clk);
    chk("R1 reset strobes", 64'({busCsN, busOeN, busWeN}), 64'(7));
    chk("R1 reset lanes", 64'(busBeN), 64'(4'hF));
    chk("R1 reset flags", 64'({done, rdValid, busy}), 64'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", 64'({busCsN, busOeN, busWeN, busBeN}), 64'(7'h7F));
    chk("R1 idle flags", 64'({done, rdValid, busy}), 64'(0));

    // sweep: direction x strobe minimum x gap x ready delay
    for (int rd = 0; rd < 2; rd++)
      for (int fi = 0; fi < 4; fi++)
        for (int rdn = 0; rdn < 4; rdn++)
          for (int w = 0; w < 4; w++) begin
            for (int i = 0; i < 16; i++) maskVec[i] = 4'(i % 8);
            if (rd == 0 && w == 2) maskVec[1] = 4'hF;
            runBurst(rd[0], 26'(32'h0012_3400 + 32'(fi * 256 + rdn * 16 + w * 4)),
                     (rdfList[fi] + rdn + w) % 4, (rdn == 2), rdfList[fi], rdn, w,
                     (w == 1 && rdn == 3));
          end

    for (int i = 0; i < 16; i++) maskVec[i] = 4'(i % 8);
    // R6 wrap of the 26-bit address
    runBurst(1'b1, 26'h3FF_FFF8, 3, 1'b0, 0, 1, 0, 1'b0);
    runBurst(1'b0, 26'h3FF_FFFC, 2, 1'b0, 3, 0, 1, 1'b0);
    // R13 longest burst
    runBurst(1'b0, 26'h000_0100, 15, 1'b0, 2, 0, 0, 1'b0);
    runBurst(1'b1, 26'h000_0200, 15, 1'b1, 0, 1, 0, 1'b0);
    // R12 long stall on ready
    runBurst(1'b1, 26'h100_0000, 1, 1'b0, 5, 2, 300, 1'b0);
    runBurst(1'b0, 26'h100_0040, 0, 1'b0, 5, 2, 300, 1'b0);
    // R9 single masked write beat
    maskVec[0] = 4'hF;
    runBurst(1'b0, 26'h020_0000, 0, 1'b0, 3, 1, 0, 1'b0);
    runBurst(1'b0, 26'h020_0010, 0, 1'b0, 12, 1, 2, 1'b0);
    // R9 masked beat inside a burst, R11 start while busy
    maskVec[0] = 4'h0; maskVec[2] = 4'hF;
    runBurst(1'b0, 26'h030_0000, 3, 1'b0, 1, 2, 1, 1'b1);

    finishRun();
  end

endmodule